// File: doc/BRIEF.md
# Sampling-Chip Serial Register Loader

This controller loads one 8-bit value into an external switched-capacitor sampling chip over its slow serial port. The port has a data line, a serial clock, a 4-bit address bus that selects which internal register the serial clock feeds, a write gate that lets the chip's sampling logic advance its write-shift register, and a sampling enable that keeps the sampling wave running. Two targets are supported: the configuration register and the write-shift register. Loading 0x55 into the write-shift register, for example, sets up cascaded four-channel operation with 2048 samples per channel.

A host raises `req_valid` with a target select and a data byte. When the block is idle it takes the request and puts the target's address code on the bus. It drops the write gate for the whole transfer, then runs a setup phase and a strobe phase that shifts the byte out, most significant bit first, one bit per serial clock pulse. After one guard period it returns the write gate to the level the host asks for. The sampling enable is never touched, so the sampling wave keeps running during a load. The write gate is held low because the chip has no shadow register: if the gate stayed high, the running wave could move the write-shift register while it is being loaded.

Top module: `srl_loader`

## Requirements
- R1: When `busy` is low and `req_valid` is high at a clock edge, the request is taken: `busy` is high from the next cycle for exactly 17*HALF clock cycles, then falls.
- R2: While `busy` is high, `addr` holds 4'b1100 when `req_target` was 0 (configuration register) and 4'b1101 when it was 1 (write-shift register). While idle, `addr` holds the parameter `DEF_ADDR`.
- R3: Each load makes exactly 8 high pulses on `ser_clk`, each HALF cycles long and separated by HALF low cycles. The first rising edge comes HALF cycles after `busy` rises. `ser_clk` is low whenever `busy` is low.
- R4: Data goes out most significant bit first: the value of `ser_dat` at the j-th rising `ser_clk` (j = 0..7) equals bit 7-j of the byte that was taken. `ser_dat` changes only together with a falling `ser_clk`, or in the first busy cycle.
- R5: `wr_gate` is low for every cycle that `busy` is high. This includes exactly HALF cycles with `ser_clk` low after the last high pulse ends. While idle, `wr_gate` follows `wr_gate_in`.
- R6: `smp_en` follows `run_en` in every cycle, both during a load and while idle.
- R7: A request presented while `busy` is high is ignored: the shifted bits, the address code and the load length are those of the accepted request, and no load follows once `busy` falls.
- R8: Loading 0x55 into the write-shift register target produces the bit sequence 0,1,0,1,0,1,0,1 on `ser_dat` at the rising `ser_clk` edges.
- R9: During and right after reset, `busy` and `ser_clk` are low and `addr` equals `DEF_ADDR`.
- R10: A request presented in the first idle cycle after a load is accepted at once, so loads can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial clock is divided from it |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Load request, taken only while idle |
| req_target | input | 1 | 0 = configuration register, 1 = write-shift register |
| req_data | input | 8 | Byte to load |
| wr_gate_in | input | 1 | Write gate level wanted outside of loads |
| run_en | input | 1 | Sampling enable from the wave controller |
| busy | output | 1 | High from acceptance until the load completes |
| addr | output | 4 | Chip register address bus |
| ser_dat | output | 1 | Serial data to the chip |
| ser_clk | output | 1 | Serial clock to the chip |
| wr_gate | output | 1 | Write gate to the chip |
| smp_en | output | 1 | Sampling enable to the chip |

## Verification
The assertions assume that reset is held for at least one edge and that the request inputs carry known values at every edge. They make no assumption about when requests arrive, so a request raised in the middle of a load must leave the address bus and the pulse count unchanged. The stimulus changes every input on the falling clock edge. It holds `wr_gate_in` and `run_en` steady for the length of each table load, and it raises a second, conflicting request while a load is in progress to exercise the ignore path.

// File: rtl/srl_pkg.sv
// Package: shared types and constants for the serial register loader.
// Assumes a 4-bit chip address bus with fixed register codes.
package srl_pkg;

    localparam int ADDR_W = 4;

    // Address codes that route the serial clock to each chip register.
    localparam logic [ADDR_W-1:0] CODE_CFG = 4'b1100;
    localparam logic [ADDR_W-1:0] CODE_WSR = 4'b1101;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_GUARD  = 2'd3
    } srl_state_e;

    // Maps a target select onto its address code.
    function automatic logic [ADDR_W-1:0] code_for(input logic tgt);
        return tgt ? CODE_WSR : CODE_CFG;
    endfunction

endpackage

// File: rtl/srl_tick.sv
// Module: half-period timer for the serial clock.
// While run is high it counts system clocks modulo HALF and pulses tick on
// the last count of each half period. While run is low it is held at zero,
// so every load starts on a half-period boundary.
module srl_tick #(
    parameter int HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    // Half-period counter, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/srl_shreg.sv
// Module: parallel-load, MSB-first output shift register.
// The output always shows the current most significant bit. A load takes
// priority over a shift in the same cycle.
module srl_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sh;

    // Holds the outgoing byte; moves one place toward the MSB per shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= load_val;
        end else if (shift) begin
            sh <= {sh[W-2:0], 1'b0};
        end
    end

    assign msb = sh[W-1];

endmodule

// File: rtl/srl_seq.sv
// Module: load sequencer.
// Steps through idle, setup (one low half period with the address and first
// bit settled), strobe (2*W-1 alternating half periods starting high, so W
// high pulses) and guard (one low half period), advancing on each tick.
// Assumes tick is aligned to the state changes (timer cleared while idle).
module srl_seq
    import srl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_target,
    input  logic       tick,
    output srl_state_e state,
    output logic       tgt,
    output logic       sclk,
    output logic       load,
    output logic       shift
);
    localparam int PHASES = 2 * W - 1;
    localparam int HW     = $clog2(PHASES);
    localparam logic [HW-1:0] LAST_PH = HW'(PHASES - 1);

    logic [HW-1:0] ph;
    logic          accept;

    assign accept = (state == ST_IDLE) && req_valid;
    assign load   = accept;
    // Shift on every falling serial clock inside the strobe phase.
    assign shift  = (state == ST_STROBE) && tick && sclk && (ph != LAST_PH);

    // State, half-phase index, serial clock level and latched target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ph    <= '0;
            sclk  <= 1'b0;
            tgt   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_SETUP;
                        tgt   <= req_target;
                        sclk  <= 1'b0;
                        ph    <= '0;
                    end
                end
                ST_SETUP: begin
                    if (tick) begin
                        state <= ST_STROBE;
                        sclk  <= 1'b1;
                        ph    <= '0;
                    end
                end
                ST_STROBE: begin
                    if (tick) begin
                        if (ph == LAST_PH) begin
                            state <= ST_GUARD;
                            sclk  <= 1'b0;
                        end else begin
                            ph   <= ph + 1'b1;
                            sclk <= ~sclk;
                        end
                    end
                end
                ST_GUARD: begin
                    if (tick) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/srl_loader.sv
// Module: top of the serial register loader.
// Takes one request at a time, drives the address code of the selected
// register, holds the write gate low for the whole load and shifts the byte
// out MSB first. The sampling enable is passed through unchanged.
// Assumes HALF >= 1 and the 4-bit chip address bus from srl_pkg.
module srl_loader
    import srl_pkg::*;
#(
    parameter int               W        = 8,
    parameter int               HALF     = 3,
    parameter logic [ADDR_W-1:0] DEF_ADDR = 4'b0111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_target,
    input  logic [W-1:0]      req_data,
    input  logic              wr_gate_in,
    input  logic              run_en,
    output logic              busy,
    output logic [ADDR_W-1:0] addr,
    output logic              ser_dat,
    output logic              ser_clk,
    output logic              wr_gate,
    output logic              smp_en
);
    srl_state_e state;
    logic       tgt;
    logic       tick;
    logic       load;
    logic       shift;

    assign busy = (state != ST_IDLE);

    srl_tick #(.HALF(HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    srl_seq #(.W(W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_target (req_target),
        .tick       (tick),
        .state      (state),
        .tgt        (tgt),
        .sclk       (ser_clk),
        .load       (load),
        .shift      (shift)
    );

    srl_shreg #(.W(W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (req_data),
        .shift    (shift),
        .msb      (ser_dat)
    );

    // Address bus: target code during a load, default readout code otherwise.
    always_comb begin
        addr = busy ? code_for(tgt) : DEF_ADDR;
    end

    // Write gate forced low during a load; the sampling enable passes through.
    always_comb begin
        wr_gate = busy ? 1'b0 : wr_gate_in;
        smp_en  = run_en;
    end

endmodule

// File: rtl/srl_loader_chk.sv
// Module: property checker for srl_loader, attached by bind.
// Observes ports only; counts serial clock pulses per load itself.
module srl_loader_chk
    import srl_pkg::*;
#(
    parameter int               W        = 8,
    parameter int               HALF     = 3,
    parameter logic [ADDR_W-1:0] DEF_ADDR = 4'b0111
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic [ADDR_W-1:0] addr,
    input logic              ser_dat,
    input logic              ser_clk,
    input logic              wr_gate
);
    logic [7:0] pulses;
    logic       clk_d;

    // Counts rising serial clock edges within the current load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulses <= '0;
            clk_d  <= 1'b0;
        end else begin
            clk_d <= ser_clk;
            if (!busy) begin
                pulses <= '0;
            end else if (ser_clk && !clk_d) begin
                pulses <= pulses + 1'b1;
            end
        end
    end

    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    a_r2_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (addr == CODE_CFG || addr == CODE_WSR));

    a_r2_idle_default: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (addr == DEF_ADDR));

    a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_clk);

    a_r3_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (pulses == 8'(W)));

    a_r4_data_timing: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_dat) |-> ($fell(ser_clk) || $rose(busy)));

    a_r5_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || ser_clk) |-> !wr_gate);

    a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr));

endmodule

bind srl_loader srl_loader_chk #(.W(W), .HALF(HALF), .DEF_ADDR(DEF_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .addr      (addr),
    .ser_dat   (ser_dat),
    .ser_clk   (ser_clk),
    .wr_gate   (wr_gate)
);

// File: tb/tb_srl_loader.sv
// Bench: walks a vector table of loads, then directed reset, ignore and
// back-to-back tests. Inputs change and outputs are sampled on falling edges.
module tb_srl_loader;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;
    localparam logic [3:0] DEF = 4'b0111;
    localparam int NV         = 6;

    // Vector: {target, data[7:0], wr_gate_in, run_en, expected addr[3:0]}
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 8'h55, 1'b1, 1'b1, 4'b1101},
        {1'b0, 8'hA5, 1'b1, 1'b1, 4'b1100},
        {1'b0, 8'h00, 1'b0, 1'b1, 4'b1100},
        {1'b1, 8'hFF, 1'b1, 1'b0, 4'b1101},
        {1'b0, 8'h80, 1'b0, 1'b0, 4'b1100},
        {1'b1, 8'h01, 1'b1, 1'b1, 4'b1101}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_target = 1'b0;
    logic [7:0] req_data = 8'h00;
    logic       wr_gate_in = 1'b1;
    logic       run_en = 1'b1;
    logic       busy, ser_dat, ser_clk, wr_gate, smp_en;
    logic [3:0] addr;

    int n_chk = 0;
    int n_bad = 0;

    srl_loader #(.W(8), .HALF(HALF), .DEF_ADDR(DEF)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
        .req_data(req_data), .wr_gate_in(wr_gate_in), .run_en(run_en),
        .busy(busy), .addr(addr), .ser_dat(ser_dat), .ser_clk(ser_clk),
        .wr_gate(wr_gate), .smp_en(smp_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Runs one load starting at a falling edge; optionally raises a
    // conflicting request mid-load. Returns at the first idle falling edge.
    task automatic run_load(input logic tgt, input logic [7:0] dat, input logic gin,
                            input logic ren, input logic [3:0] exp_addr, input bit inject);
        int   cyc = 0, rises = 0, tail = 0;
        logic [7:0] bits = '0;
        bit   addr_bad = 0, gate_bad = 0, en_bad = 0, dat_bad = 0;
        logic pclk = 1'b0, pdat;
        req_valid = 1'b1; req_target = tgt; req_data = dat;
        wr_gate_in = gin; run_en = ren;
        @(negedge clk);
        req_valid = 1'b0;
        pdat = ser_dat;
        while (busy && cyc < 1000) begin
            if (addr != exp_addr) addr_bad = 1;
            if (wr_gate) gate_bad = 1;
            if (smp_en != ren) en_bad = 1;
            if (cyc > 0 && ser_dat != pdat && !(pclk && !ser_clk)) dat_bad = 1;
            if (ser_clk && !pclk) begin
                rises++;
                bits = {bits[6:0], ser_dat};
            end
            if (rises == 8 && !ser_clk) tail++;
            pclk = ser_clk; pdat = ser_dat;
            if (inject && cyc == 5) begin
                req_valid = 1'b1; req_target = ~tgt; req_data = ~dat;
            end else begin
                req_valid = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(cyc == 17*HALF, "R1 load length", cyc, 17*HALF);
        chk(!addr_bad, "R2 address code during load", addr_bad, 0);
        chk(rises == 8, "R3 serial clock pulse count", rises, 8);
        chk(bits == dat, "R4 MSB-first bits", bits, dat);
        chk(!dat_bad, "R4 data changes only on falling clock", dat_bad, 0);
        chk(!gate_bad, "R5 write gate low during load", gate_bad, 0);
        chk(tail == HALF, "R5 guard low period", tail, HALF);
        chk(!en_bad, "R6 sampling enable kept", en_bad, 0);
        chk(addr == DEF, "R2 default address when idle", addr, DEF);
        chk(wr_gate == gin, "R5 write gate restored", wr_gate, gin);
        if (inject) begin
            repeat (3) begin
                chk(!busy && addr == DEF, "R7 ignored request starts no load", busy, 0);
                @(negedge clk);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!busy, "R9 busy low in reset", busy, 0);
        chk(!ser_clk, "R9 serial clock low in reset", ser_clk, 0);
        chk(addr == DEF, "R9 default address in reset", addr, DEF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && addr == DEF, "R9 idle after reset", busy, 0);
        wr_gate_in = 1'b0;
        #1;
        chk(wr_gate == 1'b0, "R5 gate follows input when idle", wr_gate, 0);
        wr_gate_in = 1'b1;
        #1;
        chk(wr_gate == 1'b1, "R5 gate follows input when idle", wr_gate, 1);
        @(negedge clk);

        // Table walk (first entry is the R8 pattern 0x55 to write-shift target)
        for (int i = 0; i < NV; i++) begin
            run_load(VEC[i][14], VEC[i][13:6], VEC[i][5], VEC[i][4], VEC[i][3:0], 1'b0);
            @(negedge clk);
        end

        // R7: conflicting request during a load is ignored
        run_load(1'b0, 8'h3C, 1'b1, 1'b1, 4'b1100, 1'b1);

        // R10: back-to-back loads, second request in first idle cycle
        run_load(1'b1, 8'hC3, 1'b1, 1'b1, 4'b1101, 1'b0);
        run_load(1'b0, 8'h96, 1'b0, 1'b1, 4'b1100, 1'b0);
        chk(1'b1, "R10 back-to-back accepted", 1, 1);

        // R8: explicit 0x55 write-shift load again with gate low outside
        run_load(1'b1, 8'h55, 1'b0, 1'b1, 4'b1101, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule